// File: doc/BRIEF.md
# Media integer arithmetic unit

This block performs the scalar integer operations that audio and video kernels lean on: a rounding average, absolute differences in signed and unsigned form, an absolute-difference accumulate, and signed and unsigned minimum and maximum. Operands are `XLEN` bits wide, with a default of 64. A 4-bit opcode picks the operation. Two source operands feed every operation, and a third operand serves as the running sum for the accumulate form.

The outputs are registered. A result captured on one rising clock edge appears on the outputs from that edge onward. When the record input is set, the unit also produces a 4-bit condition field and pulses a write-enable for it. The field holds a sign classification of the result, taken as a signed value, together with a copy of a sticky overflow input. All arithmetic wraps modulo 2^XLEN, and nothing saturates. The surrounding pipeline handles operand fetch, writeback, looping and decode.

Top module: `media_alu`

## Requirements
- R1: Opcode 0 (rounding average) returns bits XLEN..1 of the (XLEN+1)-bit sum A + B + 1. Both operands are zero-extended, so the carry is kept: averaging all-ones with all-ones gives all-ones.
- R2: Opcode 1 (signed absolute difference) compares A and B as signed. If A < B it returns ~A + B + 1, otherwise ~B + A + 1.
- R3: Opcode 2 (unsigned absolute difference) uses the same complement-add formation, but compares A and B as unsigned.
- R4: Opcode 3 (accumulate) returns ACC plus the unsigned absolute difference of A and B, truncated to XLEN bits. The carry out is dropped.
- R5: Opcodes 4 (signed) and 5 (unsigned) return A when A < B, otherwise B.
- R6: Opcodes 6 (signed) and 7 (unsigned) return A when A > B, otherwise B.
- R7: When A equals B, every absolute difference is zero and min/max return B.
- R8: The condition field is laid out as bit 3 = result negative, bit 2 = result positive, bit 1 = result zero, bit 0 = copy of the sticky overflow input. Exactly one of bits 3..1 is set after a write.
- R9: With record set and a valid opcode, the condition field is loaded and its write-enable is 1 for that result. With record clear, the field keeps its previous value and the write-enable is 0.
- R10: Opcodes 8 to 15 are unused. They give a zero result, a write-enable of 0 and an unchanged condition field, whatever the record input is.
- R11: Outputs change on the rising edge that samples the inputs. Reset (active low) clears the result, the condition field and the write-enable.
- R12: The signed absolute difference of the most negative value and the most positive value wraps to all-ones, in either operand order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation code |
| rec_i | input | 1 | Record: update the condition field |
| so_i | input | 1 | Sticky summary-overflow bit to copy into the field |
| src_a_i | input | XLEN | Operand A |
| src_b_i | input | XLEN | Operand B |
| acc_i | input | XLEN | Accumulator operand for the accumulate form |
| res_o | output | XLEN | Registered result |
| cr_o | output | 4 | Registered condition field |
| cr_we_o | output | 1 | Condition-field write-enable for the current result |

## Verification
The assertions assume that the opcode, record and overflow inputs are known (not X) on every sampling edge after reset. They also assume operands may take any bit pattern, with no invariant tying the accumulator to A or B. The bench drives every input on the falling edge and holds it stable across the rising edge, which keeps all of them defined. Invalid opcodes are applied on purpose, both with record set and with record clear, so that the hold and zero-result properties are actually exercised rather than passing vacuously.

// File: rtl/media_alu_pkg.sv
package media_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AVG    = 4'd0,
    OP_ABSDS  = 4'd1,
    OP_ABSDU  = 4'd2,
    OP_ABSACC = 4'd3,
    OP_MINS   = 4'd4,
    OP_MINU   = 4'd5,
    OP_MAXS   = 4'd6,
    OP_MAXU   = 4'd7
  } media_op_e;

  // condition field bit positions
  localparam int CR_LT = 3;
  localparam int CR_GT = 2;
  localparam int CR_EQ = 1;
  localparam int CR_SO = 0;
  localparam int CR_W  = 4;

endpackage

// File: rtl/media_alu_absdiff.sv
module media_alu_absdiff #(
  parameter int XLEN       = 64,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] diff_o,
  output logic            a_lt_b_o
);

  logic lt_w;

  generate
    if (SIGNED_CMP) begin : g_signed
      assign lt_w = $signed(a_i) < $signed(b_i);
    end else begin : g_unsigned
      assign lt_w = a_i < b_i;
    end
  endgenerate

  function automatic logic [XLEN-1:0] cpl_add(input logic [XLEN-1:0] sub,
                                              input logic [XLEN-1:0] add);
    return (~sub) + add + XLEN'(1);
  endfunction

  assign a_lt_b_o = lt_w;
  assign diff_o   = lt_w ? cpl_add(a_i, b_i) : cpl_add(b_i, a_i);

  // R7: zero difference exactly when the operands match
  p_zero_iff_eq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_i == b_i) == (diff_o == '0));

  // R2 / R3: complement-add agrees with plain subtraction in the chosen direction
  p_absd_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a_lt_b_o |-> (diff_o == b_i - a_i));

endmodule

// File: rtl/media_alu_minmax.sv
module media_alu_minmax #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            is_signed_i,
  input  logic            is_max_i,
  output logic [XLEN-1:0] y_o
);

  logic lt_w, gt_w;

  always_comb begin
    if (is_signed_i) begin
      lt_w = $signed(a_i) < $signed(b_i);
      gt_w = $signed(a_i) > $signed(b_i);
    end else begin
      lt_w = a_i < b_i;
      gt_w = a_i > b_i;
    end
  end

  assign y_o = is_max_i ? (gt_w ? a_i : b_i) : (lt_w ? a_i : b_i);

  // R5: selection always returns one of the operands
  p_pick_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (y_o == a_i) || (y_o == b_i));

  // R6: unsigned maximum is never below either operand
  p_max_not_below_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_max_i && !is_signed_i) |-> (y_o >= a_i && y_o >= b_i));

endmodule

// File: rtl/media_alu_crgen.sv
module media_alu_crgen
  import media_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] res_i,
  input  logic            so_i,
  output logic [CR_W-1:0] cr_o
);

  logic neg_w, zero_w;

  assign neg_w  = res_i[XLEN-1];
  assign zero_w = (res_i == '0);

  always_comb begin
    cr_o        = '0;
    cr_o[CR_LT] = neg_w;
    cr_o[CR_GT] = !neg_w && !zero_w;
    cr_o[CR_EQ] = zero_w;
    cr_o[CR_SO] = so_i;
  end

  // R8: exactly one sign class flagged
  p_cr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cr_o[CR_LT:CR_EQ]) == 1);

endmodule

// File: rtl/media_alu.sv
module media_alu
  import media_alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op_i,
  input  logic            rec_i,
  input  logic            so_i,
  input  logic [XLEN-1:0] src_a_i,
  input  logic [XLEN-1:0] src_b_i,
  input  logic [XLEN-1:0] acc_i,
  output logic [XLEN-1:0] res_o,
  output logic [CR_W-1:0] cr_o,
  output logic            cr_we_o
);

  localparam int SUM_W = XLEN + 1;

  function automatic logic [XLEN-1:0] round_avg(input logic [XLEN-1:0] a,
                                                input logic [XLEN-1:0] b);
    logic [SUM_W-1:0] s;
    s = {1'b0, a} + {1'b0, b} + SUM_W'(1);
    return XLEN'(s >> 1);
  endfunction

  // named internal events
  logic [XLEN-1:0] avg_w, absds_w, absdu_w, acc_sum_w, mm_w, res_d;
  logic [CR_W-1:0] cr_d;
  logic            op_ok_w, cr_write_w;
  logic            lt_s_w, lt_u_w;

  assign op_ok_w    = (op_i[OP_W-1] == 1'b0);
  assign cr_write_w = rec_i && op_ok_w;
  assign avg_w      = round_avg(src_a_i, src_b_i);

  media_alu_absdiff #(.XLEN(XLEN), .SIGNED_CMP(1'b1)) u_absd_s (
    .clk(clk), .rst_n(rst_n), .a_i(src_a_i), .b_i(src_b_i),
    .diff_o(absds_w), .a_lt_b_o(lt_s_w));

  media_alu_absdiff #(.XLEN(XLEN), .SIGNED_CMP(1'b0)) u_absd_u (
    .clk(clk), .rst_n(rst_n), .a_i(src_a_i), .b_i(src_b_i),
    .diff_o(absdu_w), .a_lt_b_o(lt_u_w));

  assign acc_sum_w = acc_i + absdu_w;

  media_alu_minmax #(.XLEN(XLEN)) u_minmax (
    .clk(clk), .rst_n(rst_n), .a_i(src_a_i), .b_i(src_b_i),
    .is_signed_i(!op_i[0]), .is_max_i(op_i[1]), .y_o(mm_w));

  always_comb begin
    unique case (op_i)
      OP_AVG:    res_d = avg_w;
      OP_ABSDS:  res_d = absds_w;
      OP_ABSDU:  res_d = absdu_w;
      OP_ABSACC: res_d = acc_sum_w;
      OP_MINS, OP_MINU, OP_MAXS, OP_MAXU: res_d = mm_w;
      default:   res_d = '0;
    endcase
  end

  media_alu_crgen #(.XLEN(XLEN)) u_crgen (
    .clk(clk), .rst_n(rst_n), .res_i(res_d), .so_i(so_i), .cr_o(cr_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_o   <= '0;
      cr_o    <= '0;
      cr_we_o <= 1'b0;
    end else begin
      res_o   <= res_d;
      cr_we_o <= cr_write_w;
      if (cr_write_w) cr_o <= cr_d;
    end
  end

  // R9: record clear leaves the field alone and raises no write
  p_cr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_i |=> ($stable(cr_o) && !cr_we_o));

  // R10: unused opcodes yield zero with no write
  p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    op_i[OP_W-1] |=> (res_o == '0 && !cr_we_o && $stable(cr_o)));

  // R1: the average never lies outside the operand range
  p_avg_between_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_AVG) |-> ((avg_w >= src_a_i || avg_w >= src_b_i) &&
                          (avg_w <= src_a_i || avg_w <= src_b_i)));

  // R2: signed and unsigned comparisons agree when both signs are clear
  p_cmp_agree_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_a_i[XLEN-1] && !src_b_i[XLEN-1]) |-> (lt_s_w == lt_u_w));

endmodule

// File: tb/media_alu_bench.sv
module media_alu_bench;

  localparam int  XLEN       = 64;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV         = 16;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MNEG = 64'h8000_0000_0000_0000;
  localparam logic [63:0] MPOS = 64'h7FFF_FFFF_FFFF_FFFF;

  // vector table: opcode, A, B, ACC, expected result
  localparam logic [3:0]  V_OP  [NV] = '{4'd0, 4'd0, 4'd0, 4'd1, 4'd1, 4'd2, 4'd2, 4'd3,
                                         4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd4, 4'd1, 4'd1};
  localparam logic [63:0] V_A   [NV] = '{64'd3, ONES, 64'd0, 64'hFFFF_FFFF_FFFF_FFFB, MNEG,
                                         64'hFFFF_FFFF_FFFF_FFFB, 64'h10, 64'd5, 64'd0, ONES,
                                         ONES, ONES, ONES, 64'd7, 64'd7, MPOS};
  localparam logic [63:0] V_B   [NV] = '{64'd4, ONES, 64'd0, 64'd3, MPOS, 64'd3, 64'h30, 64'd9,
                                         64'd2, 64'd1, 64'd1, 64'd1, 64'd1, 64'd7, 64'd7, MNEG};
  localparam logic [63:0] V_ACC [NV] = '{64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0,
                                         64'h100, ONES, 64'd0, 64'd0, 64'd0, 64'd0, 64'd0,
                                         64'd0, 64'd0};
  localparam logic [63:0] V_EXP [NV] = '{64'd4, ONES, 64'd0, 64'd8, ONES,
                                         64'hFFFF_FFFF_FFFF_FFF8, 64'h20, 64'h104, 64'd1, ONES,
                                         64'd1, 64'd1, ONES, 64'd7, 64'd0, ONES};
  localparam string V_REQ [NV] = '{"R1", "R1", "R1", "R2", "R12", "R3", "R3", "R4",
                                   "R4", "R5", "R5", "R6", "R6", "R7", "R7", "R12"};

  logic            clk = 1'b0;
  logic            rst_n;
  logic [3:0]      op_i;
  logic            rec_i, so_i;
  logic [XLEN-1:0] src_a_i, src_b_i, acc_i, res_o;
  logic [3:0]      cr_o;
  logic            cr_we_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  media_alu #(.XLEN(XLEN)) u_media_alu (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .rec_i(rec_i), .so_i(so_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .acc_i(acc_i),
    .res_o(res_o), .cr_o(cr_o), .cr_we_o(cr_we_o));

  // R8 model: {negative, positive, zero, overflow copy}
  function automatic logic [3:0] exp_cr(input logic [63:0] r, input logic so);
    return {r[63], !r[63] && (r != 0), r == 0, so};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // drive on the falling edge, let one rising edge capture, sample at the next falling edge
  task automatic apply(input logic [3:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] acc, input logic rec, input logic so);
    op_i = op; src_a_i = a; src_b_i = b; acc_i = acc; rec_i = rec; so_i = so;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] cr_prev;
    rst_n = 1'b0; op_i = 4'd0; rec_i = 1'b1; so_i = 1'b1;
    src_a_i = ONES; src_b_i = ONES; acc_i = ONES;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "reset res", res_o, 64'd0);
    check("R11", "reset cr", {60'd0, cr_o}, 64'd0);
    check("R11", "reset we", {63'd0, cr_we_o}, 64'd0);
    rst_n = 1'b1;

    // table walk, record set, overflow copy alternating
    for (int i = 0; i < NV; i++) begin
      apply(V_OP[i], V_A[i], V_B[i], V_ACC[i], 1'b1, 1'(i % 2));
      check(V_REQ[i], "result", res_o, V_EXP[i]);
      check("R8", "cr", {60'd0, cr_o}, {60'd0, exp_cr(V_EXP[i], 1'(i % 2))});
      check("R9", "we", {63'd0, cr_we_o}, 64'd1);
    end

    // R11: result visible exactly one edge after capture
    op_i = 4'd5; src_a_i = 64'd2; src_b_i = 64'd9; acc_i = 0; rec_i = 1'b0; so_i = 1'b0;
    @(posedge clk); #1;
    check("R11", "one-edge latency", res_o, 64'd2);
    @(negedge clk);

    // R9: record clear holds field (last table result was all ones, so=1)
    cr_prev = cr_o;
    apply(4'd2, 64'd0, 64'd0, 64'd0, 1'b0, 1'b0);
    check("R9", "hold cr", {60'd0, cr_o}, {60'd0, cr_prev});
    check("R9", "no we", {63'd0, cr_we_o}, 64'd0);
    check("R7", "absdu equal", res_o, 64'd0);

    // R10: unused codes with record set
    apply(4'd9, 64'd5, 64'd1, 64'd3, 1'b1, 1'b0);
    check("R10", "bad op res", res_o, 64'd0);
    check("R10", "bad op we", {63'd0, cr_we_o}, 64'd0);
    check("R10", "bad op cr", {60'd0, cr_o}, {60'd0, cr_prev});
    apply(4'd15, ONES, 64'd1, 64'd1, 1'b0, 1'b1);
    check("R10", "bad op 15 res", res_o, 64'd0);

    // R6 signed: most positive vs most negative
    apply(4'd6, MPOS, MNEG, 64'd0, 1'b1, 1'b0);
    check("R6", "maxs extremes", res_o, MPOS);
    check("R8", "positive cr", {60'd0, cr_o}, 64'h4);

    // R5 signed minimum of the same pair, negative result
    apply(4'd4, MPOS, MNEG, 64'd0, 1'b1, 1'b1);
    check("R5", "mins extremes", res_o, MNEG);
    check("R8", "negative cr", {60'd0, cr_o}, 64'h9);

    // R2: signed comparison flips direction against unsigned
    apply(4'd1, 64'd1, ONES, 64'd0, 1'b0, 1'b0);
    check("R2", "absds 1,-1", res_o, 64'd2);
    apply(4'd2, 64'd1, ONES, 64'd0, 1'b0, 1'b0);
    check("R3", "absdu 1,max", res_o, 64'hFFFF_FFFF_FFFF_FFFE);

    // R1: odd sum rounds up
    apply(4'd0, 64'd6, 64'd9, 64'd0, 1'b0, 1'b0);
    check("R1", "avg round", res_o, 64'd8);

    // R11: reset mid-run clears state
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R11", "re-reset res", res_o, 64'd0);
    check("R11", "re-reset cr", {60'd0, cr_o}, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule